// File: doc/BRIEF.md
# Universal registered bus transceiver

This block moves data between an A bus and a B bus in both directions. The bus is 18 bits wide by default and the data is not inverted. Each direction has its own storage stage, controlled by two signals. A level control makes the stage transparent: the output follows the input within the same cycle. When that control is low, the stage holds its value and loads new data only when its capture strobe falls. Each direction also has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low. Both enables drive per-bit enable flags that an enclosing pad ring or wrapper uses to control the bus drivers.

The block contains no internal tri-states. Each bus side has a separate input vector, output vector and enable vector. The storage is synchronous to a system clock `clk`, which samples the capture strobes. A strobe fall is seen at the first `clk` edge where the strobe reads low after it read high at the edge before. An active-low power-on reset clears both stored words and holds all enable flags off while it is asserted.

Top module: `ubx_transceiver`

## Requirements
- R1: While `rst_n` is low, every bit of `a_oe` and `b_oe` is 0 and both stored words are cleared. After reset, with the level controls low and no strobe fall, `b_out` and `a_out` read 0.
- R2: Both paths carry all WIDTH bits unchanged and non-inverted. Bit i of an output comes from bit i of the opposite input.
- R3: While `ab_le` is 1, `b_out` equals `a_in` in the same cycle, with no clock edge needed. While `ba_le` is 1, `a_out` equals `b_in` in the same way.
- R4: While a level control is 0 and its strobe makes no falling transition, the output of that direction holds its stored value, whatever its input does.
- R5: While a level control is 0, a `clk` edge at which its strobe reads 0, after reading 1 at the previous edge, loads the input present at that edge. The output shows the loaded value from then on.
- R6: When a level control goes from 1 to 0, the output keeps the input value sampled at the last `clk` edge at which the control was 1. It keeps that value until the next strobe fall.
- R7: `b_oe` is all ones when `ab_oe` is 1 and all zeros when `ab_oe` is 0 (active high, outside reset).
- R8: `a_oe` is all ones when `ba_oe_n` is 0 and all zeros when `ba_oe_n` is 1 (active low, outside reset).
- R9: Turning an output enable off leaves its stored word untouched. Data loaded while the enable is off appears on the output when the enable comes back on.
- R10: The two directions are independent. Controls and data of one direction never change the output or enable of the other.
- R11: A rising strobe transition with the level control at 0 loads nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes and clocks storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | WIDTH | Data received from the A bus |
| b_in | input | WIDTH | Data received from the B bus |
| ab_le | input | 1 | A-to-B transparency control, 1 = transparent |
| ab_cp | input | 1 | A-to-B capture strobe, loads on its fall |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A transparency control, 1 = transparent |
| ba_cp | input | 1 | B-to-A capture strobe, loads on its fall |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | WIDTH | Data presented to the B bus |
| b_oe | output | WIDTH | Per-bit drive enables for the B bus |
| a_out | output | WIDTH | Data presented to the A bus |
| a_oe | output | WIDTH | Per-bit drive enables for the A bus |

## Verification
Directed runs first hold each direction in transparent mode while the data walks through alternating, all-ones and single-bit patterns. This separates real pass-through from a swapped or inverted bit. Strobe sequences then exercise the capture: a rise alone, a steady high level, a steady low level and a fall, each with fresh data on the input. These show that only the falling transition loads and that a rising-edge variant is wrong. The enables are toggled around a capture to show that gating output drive does not touch the stored word. A long random run drives both directions at once against a behavioural model and exposes any crosstalk between the paths.

// File: rtl/ubx_pkg.sv
package ubx_pkg;

   // Which level of an output-enable input turns the drivers on.
   typedef enum logic {
      OE_ACT_HIGH = 1'b0,
      OE_ACT_LOW  = 1'b1
   } oe_pol_e;

   // Which strobe transition loads the storage stage.
   typedef enum logic {
      CAP_FALL = 1'b0,
      CAP_RISE = 1'b1
   } cap_edge_e;

   localparam int unsigned UBX_DEF_WIDTH = 18;

endpackage

// File: rtl/ubx_strobe_det.sv
module ubx_strobe_det #(
   parameter ubx_pkg::cap_edge_e EDGE = ubx_pkg::CAP_FALL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cp,
   output logic strobe
);

   logic cp_q;

   // Previous strobe level, cleared so reset never fakes a transition.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cp_q <= 1'b0;
      else        cp_q <= cp;
   end

   generate
      if (EDGE == ubx_pkg::CAP_FALL) begin : g_fall
         assign strobe = cp_q & ~cp;
      end else begin : g_rise
         assign strobe = ~cp_q & cp;
      end
   endgenerate

endmodule

// File: rtl/ubx_hold_cell.sv
module ubx_hold_cell #(
   parameter int unsigned WIDTH = ubx_pkg::UBX_DEF_WIDTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             le,
   input  logic             strobe,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] y
);

   logic [WIDTH-1:0] held_q;
   logic             load;

   // Transparent phase keeps tracking the input so that the value at
   // the last edge with le high remains once le drops.
   assign load = le | strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held_q <= '0;
      else if (load) held_q <= d;
   end

   assign y = le ? d : held_q;

endmodule

// File: rtl/ubx_drive_gate.sv
module ubx_drive_gate #(
   parameter int unsigned       WIDTH = ubx_pkg::UBX_DEF_WIDTH,
   parameter ubx_pkg::oe_pol_e  POL   = ubx_pkg::OE_ACT_HIGH
) (
   input  logic             rst_n,
   input  logic             oe_pin,
   input  logic [WIDTH-1:0] y,
   output logic [WIDTH-1:0] data,
   output logic [WIDTH-1:0] en
);

   logic active;

   generate
      if (POL == ubx_pkg::OE_ACT_HIGH) begin : g_hi
         assign active = oe_pin & rst_n;
      end else begin : g_lo
         assign active = ~oe_pin & rst_n;
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < WIDTH; gi++) begin : g_bit
         assign en[gi] = active;
      end
   endgenerate

   assign data = y;

endmodule

// File: rtl/ubx_lane.sv
module ubx_lane #(
   parameter int unsigned        WIDTH = ubx_pkg::UBX_DEF_WIDTH,
   parameter ubx_pkg::oe_pol_e   POL   = ubx_pkg::OE_ACT_HIGH,
   parameter ubx_pkg::cap_edge_e EDGE  = ubx_pkg::CAP_FALL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   input  logic             le,
   input  logic             cp,
   input  logic             oe_pin,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] q_en
);

   logic             strobe;
   logic [WIDTH-1:0] y;

   ubx_strobe_det #(.EDGE(EDGE)) i_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .cp     (cp),
      .strobe (strobe)
   );

   ubx_hold_cell #(.WIDTH(WIDTH)) i_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .le     (le),
      .strobe (strobe),
      .d      (d),
      .y      (y)
   );

   ubx_drive_gate #(.WIDTH(WIDTH), .POL(POL)) i_gate (
      .rst_n  (rst_n),
      .oe_pin (oe_pin),
      .y      (y),
      .data   (q),
      .en     (q_en)
   );

endmodule

// File: rtl/ubx_transceiver.sv
module ubx_transceiver #(
   parameter int unsigned        WIDTH     = ubx_pkg::UBX_DEF_WIDTH,
   parameter ubx_pkg::oe_pol_e   AB_OE_POL = ubx_pkg::OE_ACT_HIGH,
   parameter ubx_pkg::oe_pol_e   BA_OE_POL = ubx_pkg::OE_ACT_LOW,
   parameter ubx_pkg::cap_edge_e CAP_EDGE  = ubx_pkg::CAP_FALL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             ab_le,
   input  logic             ab_cp,
   input  logic             ab_oe,
   input  logic             ba_le,
   input  logic             ba_cp,
   input  logic             ba_oe_n,
   output logic [WIDTH-1:0] b_out,
   output logic [WIDTH-1:0] b_oe,
   output logic [WIDTH-1:0] a_out,
   output logic [WIDTH-1:0] a_oe
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("ubx_transceiver: WIDTH must be at least 1");
      end
   endgenerate

   ubx_lane #(.WIDTH(WIDTH), .POL(AB_OE_POL), .EDGE(CAP_EDGE)) i_lane_ab (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (a_in),
      .le     (ab_le),
      .cp     (ab_cp),
      .oe_pin (ab_oe),
      .q      (b_out),
      .q_en   (b_oe)
   );

   ubx_lane #(.WIDTH(WIDTH), .POL(BA_OE_POL), .EDGE(CAP_EDGE)) i_lane_ba (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (b_in),
      .le     (ba_le),
      .cp     (ba_cp),
      .oe_pin (ba_oe_n),
      .q      (a_out),
      .q_en   (a_oe)
   );

endmodule

// File: rtl/ubx_transceiver_chk.sv
module ubx_transceiver_chk #(
   parameter int unsigned WIDTH = ubx_pkg::UBX_DEF_WIDTH
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] b_in,
   input logic             ab_le,
   input logic             ab_cp,
   input logic             ab_oe,
   input logic             ba_le,
   input logic             ba_cp,
   input logic             ba_oe_n,
   input logic [WIDTH-1:0] b_out,
   input logic [WIDTH-1:0] b_oe,
   input logic [WIDTH-1:0] a_out,
   input logic [WIDTH-1:0] a_oe
);

   // R1: drivers stay off throughout reset
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_off_r1: assert (b_oe == '0 && a_oe == '0)
            else $error("enable flag set during reset");
      end
   end

   // R3: transparent A-to-B
   p_transparent_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ab_le |-> (b_out == a_in));

   // R3: transparent B-to-A
   p_transparent_ba_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ba_le |-> (a_out == b_in));

   // R4: no fall, no level -> output stable
   p_hold_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_le && $past(!ab_le) && !($past(ab_cp, 2) && !$past(ab_cp)))
      |-> $stable(b_out));

   // R5: strobe fall loads the input present at that edge
   p_capture_ab_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !ab_le && !ab_cp && $past(ab_cp))
      |=> (ab_le || b_out == $past(a_in)));

   // R7: active-high enable on the B side
   p_oe_ab_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ab_oe |-> (b_oe == {WIDTH{1'b1}}));

   // R8: active-low enable on the A side
   p_oe_ba_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ba_oe_n |-> (a_oe == '0));

endmodule

bind ubx_transceiver ubx_transceiver_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_ubx_transceiver.sv
module test_ubx_transceiver;

   localparam int W = 18;
   localparam logic [W-1:0] ONES = {W{1'b1}};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic         ab_le = 1'b0, ab_cp = 1'b0, ab_oe = 1'b0;
   logic         ba_le = 1'b0, ba_cp = 1'b0, ba_oe_n = 1'b1;
   logic [W-1:0] b_out, b_oe, a_out, a_oe;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // behavioural reference state
   logic [W-1:0] m_ab = '0, m_ba = '0;
   logic         m_abcp = 1'b0, m_bacp = 1'b0;

   always #5 clk = ~clk;

   ubx_transceiver i_ubx_transceiver (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .ab_le(ab_le), .ab_cp(ab_cp), .ab_oe(ab_oe),
      .ba_le(ba_le), .ba_cp(ba_cp), .ba_oe_n(ba_oe_n),
      .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
   );

   task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   // compare with model mid-cycle, then advance the model on the edge
   task automatic tick(string tag);
      logic [W-1:0] eb, ea, eben, eaen;
      if (!rst_n) begin
         m_ab = '0; m_ba = '0; m_abcp = 1'b0; m_bacp = 1'b0;
      end
      #1;
      eb   = ab_le ? a_in : m_ab;
      ea   = ba_le ? b_in : m_ba;
      eben = (rst_n && ab_oe)    ? ONES : '0;
      eaen = (rst_n && !ba_oe_n) ? ONES : '0;
      check(tag, "b_out", b_out, eb);
      check(tag, "a_out", a_out, ea);
      check(tag, "b_oe",  b_oe,  eben);
      check(tag, "a_oe",  a_oe,  eaen);
      @(posedge clk);
      if (!rst_n) begin
         m_ab = '0; m_ba = '0; m_abcp = 1'b0; m_bacp = 1'b0;
      end else begin
         if (ab_le || (m_abcp && !ab_cp)) m_ab = a_in;
         if (ba_le || (m_bacp && !ba_cp)) m_ba = b_in;
         m_abcp = ab_cp;
         m_bacp = ba_cp;
      end
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         finish_run();
      end
   end

   initial begin
      @(negedge clk);
      // R1: reset state with activity on the inputs
      a_in = 18'h3C3C3; b_in = 18'h0F0F0; ab_oe = 1'b1; ba_oe_n = 1'b0;
      ab_cp = 1'b1; ba_cp = 1'b1;
      tick("R1"); ab_cp = 1'b0; ba_cp = 1'b0; tick("R1");
      ab_oe = 1'b0; ba_oe_n = 1'b1;
      rst_n = 1'b1;
      tick("R1");
      check("R1", "b_out after reset", b_out, '0);
      check("R1", "a_out after reset", a_out, '0);

      // R2 / R3: transparent pass-through of distinct patterns
      ab_le = 1'b1; ba_le = 1'b1; ab_oe = 1'b1; ba_oe_n = 1'b0;
      a_in = 18'h2AAAA; b_in = 18'h15555; tick("R3");
      a_in = ONES;      b_in = 18'h00001; tick("R2");
      a_in = 18'h20000; b_in = ONES;      tick("R2");
      a_in = 18'h12345; b_in = 18'h3FEDC; tick("R3");
      check("R2", "b_out walk", b_out, 18'h12345);

      // R6: level drops; last sampled value stays
      ab_le = 1'b0; ba_le = 1'b0;
      a_in = 18'h0BEEF; b_in = 18'h1CAFE; tick("R6");
      check("R6", "b_out held", b_out, 18'h12345);
      check("R6", "a_out held", a_out, 18'h3FEDC);

      // R4: steady strobe high, then low, data moving
      ab_cp = 1'b1; ba_cp = 1'b1;
      for (int i = 0; i < 4; i++) begin
         a_in = 18'(i * 18'h0A5A5); b_in = ~a_in; tick("R4");
      end
      // R5: fall loads
      a_in = 18'h33333; b_in = 18'h0CCCC;
      ab_cp = 1'b0; ba_cp = 1'b0; tick("R5");
      check("R5", "b_out loaded", b_out, 18'h33333);
      check("R5", "a_out loaded", a_out, 18'h0CCCC);
      for (int i = 0; i < 3; i++) begin
         a_in = 18'(18'h01111 * (i + 1)); b_in = a_in ^ 18'h2F00F; tick("R4");
      end

      // R11: rising strobe loads nothing
      a_in = 18'h1F1F1; b_in = 18'h2E2E2;
      ab_cp = 1'b1; ba_cp = 1'b1; tick("R11");
      tick("R11");
      check("R11", "b_out after rise", b_out, 18'h33333);

      // R7 / R8: enable polarity
      ab_oe = 1'b0; ba_oe_n = 1'b1; tick("R7");
      check("R7", "b_oe off", b_oe, '0);
      check("R8", "a_oe off", a_oe, '0);
      ab_oe = 1'b1; tick("R7");
      ba_oe_n = 1'b0; tick("R8");
      check("R8", "a_oe on", a_oe, ONES);

      // R9: capture while disabled, then re-enable
      ab_oe = 1'b0; ba_oe_n = 1'b1;
      a_in = 18'h1E0F0; b_in = 18'h21F0E;
      ab_cp = 1'b0; ba_cp = 1'b0; tick("R9");
      a_in = 18'h00000; b_in = 18'h00000; tick("R9");
      ab_oe = 1'b1; ba_oe_n = 1'b0; tick("R9");
      check("R9", "b_out on re-enable", b_out, 18'h1E0F0);
      check("R9", "a_out on re-enable", a_out, 18'h21F0E);
      check("R9", "b_oe on re-enable", b_oe, ONES);

      // R10: independent random traffic on both directions
      for (int i = 0; i < 400; i++) begin
         a_in    = 18'($urandom);
         b_in    = 18'($urandom);
         ab_le   = ($urandom % 4) == 0;
         ba_le   = ($urandom % 3) == 0;
         ab_cp   = $urandom % 2;
         ba_cp   = $urandom % 2;
         ab_oe   = $urandom % 2;
         ba_oe_n = $urandom % 2;
         tick("R10");
      end
      // R10: one lane quiet while the other is busy
      ba_le = 1'b0; ba_cp = 1'b0; tick("R10");
      for (int i = 0; i < 20; i++) begin
         a_in = 18'($urandom); ab_le = i[0]; ab_cp = i[1];
         tick("R10");
      end

      // R1: reset mid-run clears storage
      rst_n = 1'b0; ab_le = 1'b0; ba_le = 1'b0; tick("R1");
      rst_n = 1'b1; ab_cp = 1'b0; ba_cp = 1'b0; tick("R1");
      check("R1", "b_out after second reset", b_out, '0);

      done = 1'b1;
      finish_run();
   end

endmodule